// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block is the transfer engine of a single DMA channel. A transfer control descriptor, picked from a small local store, tells it where to read, where to write, how far each address steps after every element, how many bytes make up one service (a minor loop), and how many services make up a whole job (the major loop). Each service request, whether a hardware request line, a software start or a link pulse from another channel, moves one minor loop over a simple single-beat bus master port. Each element is a read followed by a write.

When a minor loop ends, the engine can send a start pulse to another channel. When the major loop ends, it can do one of two things. It can apply signed last-address adjustments so that the next job starts from the original addresses. Or it can load a fresh descriptor named by the finished one, which lets a pair of descriptors alternate as a ring. An auto-stop bit drops the channel's request enable at job end, which is how an always-asserted request is made to run exactly one job. Software sees a sticky done flag and an optional one-cycle completion interrupt.

Top module: `dmac_chan_engine`

## Requirements
- R1: Each element is one read at the source address (m_rd high for one cycle) followed in the next cycle by one write of the read data to the destination address (m_wr). After every element, the source address moves by the signed source offset and the destination address by the signed destination offset. An offset of zero keeps an address fixed.
- R2: A service request moves exactly one minor loop of `nbytes` bytes. A request is a `sw_start` pulse, a `link_in` pulse, or `hw_req` held high while `req_en` is set.
- R3: When the last minor loop of the major loop ends and scatter-gather is off, the last-address adjustments are added after the final offset step, the iteration count is reloaded from the beginning count, and `done` is set. `done` stays set until `done_clr` is pulsed.
- R4: With minor linking enabled, every minor loop except the last gives one `link_vld` pulse carrying the minor-link channel on `link_ch`.
- R5: With major linking enabled, the final minor loop pulses the major-link channel instead of the minor-link one. With major linking disabled, the final minor loop gives no pulse.
- R6: With scatter-gather enabled, major completion makes the store entry named by the next-descriptor index the active descriptor, with its own addresses and counts. Two entries naming each other run in alternation.
- R7: If the completing descriptor has auto-stop set, `req_en` is cleared at major completion, and a still-asserted `hw_req` is no longer serviced.
- R8: `irq` pulses for one cycle at major completion only when the descriptor that just completed has its interrupt enable set.
- R9: The element size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes, and it is driven on `m_size`. Write data carries the element in the low byte lanes, with all higher bits zero.
- R10: A descriptor with size code 3, a zero byte count, or a byte count that is not a whole multiple of the element size is refused when it is loaded. In that case `err` is set, no bus cycles occur, and starts are ignored until a valid descriptor is loaded.
- R11: A start or link pulse that arrives while a minor loop is in progress is held and served as one further minor loop after the current one. Several such pulses merge into one.
- R12: After reset, `busy`, `done`, `err`, `irq`, `req_en`, `link_vld`, `m_rd` and `m_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_we | input | 1 | Write one descriptor store entry |
| desc_waddr | input | IDXW (2) | Store entry being written |
| desc_wdata | input | DESC_W | Descriptor value (package descriptor layout) |
| desc_load | input | 1 | Make store entry `desc_idx` the active descriptor |
| desc_idx | input | IDXW (2) | Entry to activate |
| req_en_set | input | 1 | Set the request enable |
| req_en_clr | input | 1 | Clear the request enable |
| sw_start | input | 1 | Software start of one minor loop |
| link_in | input | 1 | Link start pulse from another channel |
| hw_req | input | 1 | Hardware service request (level) |
| done_clr | input | 1 | Clear the done flag |
| m_rd | output | 1 | Bus read strobe |
| m_wr | output | 1 | Bus write strobe |
| m_addr | output | AW (32) | Bus byte address |
| m_size | output | 2 | Element size code |
| m_wdata | output | DW (32) | Write data, low-lane aligned |
| m_rdata | input | DW (32) | Read data, valid the cycle after m_rd |
| link_vld | output | 1 | Link pulse to another channel |
| link_ch | output | CHW (3) | Channel targeted by the link pulse |
| irq | output | 1 | Major-completion interrupt pulse |
| done | output | 1 | Sticky major-completion flag |
| err | output | 1 | Refused descriptor, channel idle |
| busy | output | 1 | Minor loop running or pending |
| req_en | output | 1 | Request enable |

## Verification
The bench uses the package defaults: a four-entry store, 32-bit addresses, 16-bit signed offsets, 3-bit link channel identifiers, and an 8-bit loop count. With these values, a two-entry ring, negative and zero offsets and every element size can be exercised within a few hundred bytes of bench memory. The short major counts (1 to 4) let the same run reach both link kinds, the reload of the iteration count, auto-stop on an always-asserted request, and the merging of starts into a held request.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int OFW  = 16;
  localparam int NBW  = 12;
  localparam int CNTW = 8;
  localparam int CHW  = 3;
  localparam int IDXW = 2;
  localparam int NDESC = 1 << IDXW;

  typedef struct packed {
    logic [AW-1:0]         saddr;
    logic [AW-1:0]         daddr;
    logic signed [OFW-1:0] soff;
    logic signed [OFW-1:0] doff;
    logic [1:0]            esize;
    logic [NBW-1:0]        nbytes;
    logic [CNTW-1:0]       biter;
    logic signed [AW-1:0]  slast;
    logic signed [AW-1:0]  dlast;
    logic                  mlink_en;
    logic [CHW-1:0]        mlink_ch;
    logic                  jlink_en;
    logic [CHW-1:0]        jlink_ch;
    logic                  sg_en;
    logic [IDXW-1:0]       next_idx;
    logic                  auto_stop;
    logic                  int_en;
  } dmac_desc_t;

  localparam int DESC_W = $bits(dmac_desc_t);

  function automatic logic [NBW-1:0] elem_bytes(input logic [1:0] sz);
    return NBW'(1) << sz;
  endfunction

  function automatic logic desc_ok(input dmac_desc_t d);
    logic [NBW-1:0] eb;
    eb = elem_bytes(d.esize);
    return (d.esize != 2'd3) && (d.nbytes != '0) && ((d.nbytes & (eb - NBW'(1))) == '0);
  endfunction

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                              input logic [OFW-1:0] off,
                                              input logic adj_en,
                                              input logic [AW-1:0] adj);
    logic [AW-1:0] ext;
    ext = {{(AW-OFW){off[OFW-1]}}, off};
    return a + ext + (adj_en ? adj : '0);
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return DW'(32'h0000_00FF);
      2'd1:    return DW'(32'h0000_FFFF);
      default: return DW'(32'hFFFF_FFFF);
    endcase
  endfunction
endpackage

// File: rtl/dmac_desc_store.sv
module dmac_desc_store
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDXW-1:0]   waddr,
  input  logic [DESC_W-1:0] wdata,
  input  logic [IDXW-1:0]   raddr,
  output logic [DESC_W-1:0] rdata
);
  logic [DESC_W-1:0] mem [NDESC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_req,
  input  logic            sw_start,
  input  logic            link_in,
  input  logic            req_en_set,
  input  logic            req_en_clr,
  input  logic            done_clr,
  input  logic            desc_load,
  input  logic [IDXW-1:0] desc_idx,
  output logic [IDXW-1:0] rd_idx,
  input  dmac_desc_t      rd_desc,
  output logic            m_rd,
  output logic            m_wr,
  output logic [AW-1:0]   m_addr,
  output logic [1:0]      m_size,
  input  logic [DW-1:0]   m_rdata,
  output logic [DW-1:0]   m_wdata,
  output logic            lk_evt,
  output logic [CHW-1:0]  lk_evt_ch,
  output logic            irq,
  output logic            done,
  output logic            err,
  output logic            busy,
  output logic            req_en
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_ERR} st_t;

  st_t             st;
  dmac_desc_t      cur;
  logic [CNTW-1:0] citer;
  logic [NBW-1:0]  bcnt;
  logic            pend;

  // named internal events
  logic [NBW-1:0] esz;
  logic elem_end, minor_end, major_evt, start_ok, adj_en, new_start;
  assign esz       = elem_bytes(cur.esize);
  assign elem_end  = (st == S_WR);
  assign minor_end = elem_end && ((bcnt + esz) == cur.nbytes);
  assign major_evt = minor_end && (citer == CNTW'(1));
  assign start_ok  = (st == S_IDLE) && (pend || (hw_req && req_en));
  assign adj_en    = major_evt && !cur.sg_en;
  assign new_start = (sw_start || link_in) && (st != S_ERR);
  assign rd_idx    = desc_load ? desc_idx : cur.next_idx;

  assign m_rd    = (st == S_RD);
  assign m_wr    = (st == S_WR);
  assign m_addr  = m_rd ? cur.saddr : cur.daddr;
  assign m_size  = cur.esize;
  assign m_wdata = m_rdata & lane_mask(cur.esize);
  assign err     = (st == S_ERR);
  assign busy    = m_rd || m_wr || pend || ((st == S_IDLE) && hw_req && req_en);

  assign lk_evt    = minor_end && (major_evt ? cur.jlink_en : cur.mlink_en);
  assign lk_evt_ch = major_evt ? cur.jlink_ch : cur.mlink_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_en <= 1'b0;
    else if (req_en_set) req_en <= 1'b1;
    else if (req_en_clr || (major_evt && cur.auto_stop)) req_en <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cur   <= '0;
      citer <= '0;
      bcnt  <= '0;
      pend  <= 1'b0;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq  <= 1'b0;
      pend <= (pend && !start_ok) || new_start;
      if (done_clr) done <= 1'b0;
      if (desc_load) begin
        cur   <= rd_desc;
        citer <= rd_desc.biter;
        bcnt  <= '0;
        pend  <= 1'b0;
        st    <= desc_ok(rd_desc) ? S_IDLE : S_ERR;
      end else begin
        case (st)
          S_IDLE: if (start_ok) st <= S_RD;
          S_RD:   st <= S_WR;
          S_WR: begin
            cur.saddr <= step_addr(cur.saddr, cur.soff, adj_en, cur.slast);
            cur.daddr <= step_addr(cur.daddr, cur.doff, adj_en, cur.dlast);
            if (!minor_end) begin
              bcnt <= bcnt + esz;
              st   <= S_RD;
            end else begin
              bcnt <= '0;
              st   <= S_IDLE;
              if (major_evt) begin
                done <= 1'b1;
                irq  <= cur.int_en;
                if (cur.sg_en) begin
                  cur   <= rd_desc;
                  citer <= rd_desc.biter;
                  if (!desc_ok(rd_desc)) st <= S_ERR;
                end else begin
                  citer <= cur.biter;
                end
              end else begin
                citer <= citer - CNTW'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr |-> $past(m_rd));
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!m_rd && !m_wr));
  // R7
  autostop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (major_evt && cur.auto_stop && !req_en_set) |=> !req_en);
  // R8
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  // R9
  lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && m_size == 2'd0) |-> (m_wdata[DW-1:8] == '0));
endmodule

// File: rtl/dmac_link.sv
module dmac_link
  import dmac_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt,
  input  logic [CHW-1:0] evt_ch,
  output logic           link_vld,
  output logic [CHW-1:0] link_ch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_vld <= 1'b0;
      link_ch  <= '0;
    end else begin
      link_vld <= evt;
      if (evt) link_ch <= evt_ch;
    end
  end
endmodule

// File: rtl/dmac_chan_engine.sv
module dmac_chan_engine
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_we,
  input  logic [IDXW-1:0]   desc_waddr,
  input  logic [DESC_W-1:0] desc_wdata,
  input  logic              desc_load,
  input  logic [IDXW-1:0]   desc_idx,
  input  logic              req_en_set,
  input  logic              req_en_clr,
  input  logic              sw_start,
  input  logic              link_in,
  input  logic              hw_req,
  input  logic              done_clr,
  output logic              m_rd,
  output logic              m_wr,
  output logic [AW-1:0]     m_addr,
  output logic [1:0]        m_size,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  output logic              link_vld,
  output logic [CHW-1:0]    link_ch,
  output logic              irq,
  output logic              done,
  output logic              err,
  output logic              busy,
  output logic              req_en
);
  logic [IDXW-1:0]   rd_idx;
  logic [DESC_W-1:0] rd_bits;
  dmac_desc_t        rd_desc;
  logic              lk_evt;
  logic [CHW-1:0]    lk_evt_ch;

  assign rd_desc = dmac_desc_t'(rd_bits);

  dmac_desc_store u_store (
    .clk(clk), .rst_n(rst_n), .we(desc_we), .waddr(desc_waddr),
    .wdata(desc_wdata), .raddr(rd_idx), .rdata(rd_bits)
  );

  dmac_seq u_seq (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_start(sw_start),
    .link_in(link_in), .req_en_set(req_en_set), .req_en_clr(req_en_clr),
    .done_clr(done_clr), .desc_load(desc_load), .desc_idx(desc_idx),
    .rd_idx(rd_idx), .rd_desc(rd_desc), .m_rd(m_rd), .m_wr(m_wr),
    .m_addr(m_addr), .m_size(m_size), .m_rdata(m_rdata), .m_wdata(m_wdata),
    .lk_evt(lk_evt), .lk_evt_ch(lk_evt_ch), .irq(irq), .done(done),
    .err(err), .busy(busy), .req_en(req_en)
  );

  dmac_link u_link (
    .clk(clk), .rst_n(rst_n), .evt(lk_evt), .evt_ch(lk_evt_ch),
    .link_vld(link_vld), .link_ch(link_ch)
  );

  // R4
  link_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_vld |-> $past(m_wr));
endmodule

// File: tb/tb_dmac_chan_engine.sv
`timescale 1ns/1ps
module tb_dmac_chan_engine;
  import dmac_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic desc_we = 0, desc_load = 0, req_en_set = 0, req_en_clr = 0;
  logic sw_start = 0, link_in = 0, hw_req = 0, done_clr = 0;
  logic [IDXW-1:0] desc_waddr = '0, desc_idx = '0;
  logic [DESC_W-1:0] desc_wdata = '0;
  logic m_rd, m_wr, link_vld, irq, done, err, busy, req_en;
  logic [AW-1:0] m_addr;
  logic [1:0] m_size;
  logic [DW-1:0] m_wdata;
  logic [DW-1:0] m_rdata = '0;
  logic [CHW-1:0] link_ch;

  dmac_chan_engine dut (.*);

  int nchk = 0, nfail = 0, obs_irq = 0, exp_irq = 0;
  bit finished = 0;

  logic [7:0] bm [0:1023];
  logic [7:0] mm [0:1023];
  logic [31:0] exp_wa[$];
  logic [31:0] exp_wd[$];
  int exp_lk[$];

  dmac_desc_t st_m [NDESC];
  dmac_desc_t act;
  logic [31:0] ms, md;
  int cit;
  bit merr, mreq;

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // bus memory
  always @(posedge clk) begin
    if (m_rd) m_rdata <= {bm[(m_addr+3)&1023], bm[(m_addr+2)&1023], bm[(m_addr+1)&1023], bm[m_addr&1023]};
    if (m_wr) for (int k = 0; k < (1 << m_size); k++) bm[(m_addr+k)&1023] = m_wdata[8*k +: 8];
  end

  // monitor compared against the reference queues every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_wr) begin
        if (exp_wa.size() == 0) chk(0, "R1 unexpected write", m_addr, 32'hFFFF_FFFF);
        else begin
          logic [31:0] ea, ed;
          ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
          chk(m_addr == ea, "R1 write address", m_addr, ea);
          chk(m_wdata == ed, "R9 write data", m_wdata, ed);
        end
      end
      if (link_vld) begin
        if (exp_lk.size() == 0) chk(0, "R4 R5 unexpected link", 32'(link_ch), 32'hFFFF_FFFF);
        else begin
          int el;
          el = exp_lk.pop_front();
          chk(int'(link_ch) == el, "R4 R5 link channel", 32'(link_ch), 32'(el));
        end
      end
      if (irq) obs_irq++;
    end
  end

  function automatic dmac_desc_t mkd(input int sa, da, so, dof, es, nb, bi, sl, dl,
                                     input int mle, mlc, jle, jlc, sg, nx, ast, ie);
    dmac_desc_t d;
    d.saddr = 32'(sa); d.daddr = 32'(da);
    d.soff = OFW'(so); d.doff = OFW'(dof);
    d.esize = 2'(es); d.nbytes = NBW'(nb); d.biter = CNTW'(bi);
    d.slast = 32'(sl); d.dlast = 32'(dl);
    d.mlink_en = 1'(mle); d.mlink_ch = CHW'(mlc);
    d.jlink_en = 1'(jle); d.jlink_ch = CHW'(jlc);
    d.sg_en = 1'(sg); d.next_idx = IDXW'(nx);
    d.auto_stop = 1'(ast); d.int_en = 1'(ie);
    return d;
  endfunction

  task automatic mdl_load(input int idx);
    int eb;
    act = st_m[idx]; ms = act.saddr; md = act.daddr; cit = int'(act.biter);
    eb = 1 << act.esize;
    merr = (act.esize == 2'd3) || (act.nbytes == 0) || ((int'(act.nbytes) % eb) != 0);
  endtask

  task automatic mdl_minor();
    int eb, n;
    bit maj;
    eb = 1 << act.esize;
    n = int'(act.nbytes) / eb;
    maj = (cit == 1);
    for (int e = 0; e < n; e++) begin
      logic [31:0] v;
      v = '0;
      for (int k = 0; k < eb; k++) v[8*k +: 8] = mm[(ms+k)&1023];
      for (int k = 0; k < eb; k++) mm[(md+k)&1023] = v[8*k +: 8];
      exp_wa.push_back(md); exp_wd.push_back(v);
      ms = ms + 32'(int'(act.soff));
      md = md + 32'(int'(act.doff));
      if (e == n-1 && maj && !act.sg_en) begin
        ms = ms + act.slast; md = md + act.dlast;
      end
    end
    if (maj) begin
      if (act.jlink_en) exp_lk.push_back(int'(act.jlink_ch));
      if (act.int_en) exp_irq++;
      if (act.auto_stop) mreq = 0;
      if (act.sg_en) mdl_load(int'(act.next_idx));
      else cit = int'(act.biter);
    end else begin
      if (act.mlink_en) exp_lk.push_back(int'(act.mlink_ch));
      cit--;
    end
  endtask

  task automatic put_desc(input int idx, input dmac_desc_t d);
    @(negedge clk);
    desc_we = 1; desc_waddr = IDXW'(idx); desc_wdata = d;
    @(negedge clk);
    desc_we = 0;
    st_m[idx] = d;
  endtask

  task automatic do_load(input int idx);
    @(negedge clk);
    desc_load = 1; desc_idx = IDXW'(idx);
    @(negedge clk);
    desc_load = 0;
    mdl_load(idx);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic kick();
    @(negedge clk);
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    if (!merr) mdl_minor();
    wait_idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      bm[i] = 8'((i*7 + 3) & 255);
      mm[i] = bm[i];
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({busy, done, err, irq, req_en, link_vld, m_rd, m_wr} == 8'h00, "R12 reset outputs",
        32'({busy, done, err, irq, req_en, link_vld, m_rd, m_wr}), 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // A: fixed destination, minor link ch1, major link ch2, interrupt (R1 R2 R3 R4 R5 R8)
    put_desc(0, mkd(32'h100, 32'h200, 4, 0, 2, 4, 2, -8, 0, 1, 1, 1, 2, 0, 0, 0, 1));
    do_load(0);
    kick();
    chk(done == 1'b0, "R2 one minor loop per start", 32'(done), 32'h0);
    kick();
    chk(done == 1'b1, "R3 done after major loop", 32'(done), 32'h1);
    chk(obs_irq == exp_irq, "R8 interrupt count", 32'(obs_irq), 32'(exp_irq));
    kick();  // addresses returned by last adjustment, count reloaded: link ch1 again
    chk(exp_wa.size() == 0 && exp_lk.size() == 0, "R3 restart after adjust", 32'(exp_wa.size()), 32'h0);
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    @(negedge clk);
    chk(done == 1'b0, "R3 done cleared", 32'(done), 32'h0);

    // B: ring of two descriptors on always-on request, auto-stop in second (R6 R7 R8)
    put_desc(1, mkd(32'h300, 32'h280, 8, 4, 2, 4, 3, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0));
    put_desc(2, mkd(32'h304, 32'h2C0, 8, 4, 2, 4, 3, 0, 0, 0, 0, 1, 5, 1, 1, 1, 1));
    do_load(1);
    @(negedge clk);
    hw_req = 1; req_en_set = 1;
    @(negedge clk);
    req_en_set = 0;
    mreq = 1;
    while (mreq) mdl_minor();
    wait_idle();
    chk(req_en == 1'b0, "R7 auto-stop cleared request enable", 32'(req_en), 32'h0);
    chk(obs_irq == exp_irq, "R8 interrupt only from enabled descriptor", 32'(obs_irq), 32'(exp_irq));
    repeat (10) @(negedge clk);
    chk(exp_wa.size() == 0 && !busy, "R7 request ignored after stop", 32'(busy), 32'h0);
    hw_req = 0;
    kick();  // ring returned to entry 1 with fresh addresses
    chk(exp_wa.size() == 0, "R6 ring reload", 32'(exp_wa.size()), 32'h0);

    // C: byte elements, negative source offset (R1 R9)
    put_desc(0, mkd(32'h00F, 32'h040, -1, 1, 0, 4, 1, 4, -4, 0, 0, 0, 0, 0, 0, 0, 0));
    do_load(0);
    kick();
    kick();
    chk(exp_wa.size() == 0, "R1 reversed byte copy", 32'(exp_wa.size()), 32'h0);

    // D: halfword elements at an odd address (R9)
    put_desc(0, mkd(32'h181, 32'h1A0, 2, 2, 1, 4, 1, -4, -4, 0, 0, 0, 0, 0, 0, 0, 0));
    do_load(0);
    kick();
    kick();
    chk(exp_wa.size() == 0, "R9 halfword copy", 32'(exp_wa.size()), 32'h0);

    // E: held starts merge into one further minor loop (R11)
    put_desc(0, mkd(32'h340, 32'h3A0, 1, 1, 0, 8, 4, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0));
    do_load(0);
    @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0;
    mdl_minor();
    repeat (3) @(negedge clk);
    link_in = 1; @(negedge clk); link_in = 0;
    @(negedge clk);
    sw_start = 1; @(negedge clk); sw_start = 0;
    mdl_minor();
    wait_idle();
    chk(exp_wa.size() == 0 && exp_lk.size() == 0, "R11 pending merged", 32'(exp_wa.size()), 32'h0);

    // F: refused descriptors (R10)
    put_desc(3, mkd(32'h100, 32'h3F0, 4, 4, 2, 6, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    do_load(3);
    chk(err == 1'b1, "R10 byte count not a multiple", 32'(err), 32'h1);
    kick();
    chk(err == 1'b1 && !busy, "R10 start ignored", 32'(err), 32'h1);
    put_desc(3, mkd(32'h100, 32'h3F0, 4, 4, 3, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    do_load(3);
    chk(err == 1'b1, "R10 size code 3", 32'(err), 32'h1);
    do_load(0);
    chk(err == 1'b0, "R10 valid load clears error", 32'(err), 32'h0);

    // final memory comparison (R1)
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 1024; i++) if (bm[i] !== mm[i]) bad++;
      chk(bad == 0, "R1 memory image", 32'(bad), 32'h0);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule